// File: doc/BRIEF.md
# Multicore Interrupt and Barrier Controller

This controller sits beside a group of `NC` processor cores and handles their interrupts and their synchronisation. Each core has an interrupt-enable bit and two pending latches, one for its hardware line and one for its software request. A core can raise the hardware interrupt of another core by giving a target index. When a core has an enabled, pending interrupt, the controller pulses that core's take strobe. The core then saves its PC into register 31 and fetches its new PC from the vector word at address `VEC_BASE + core index`. The controller computes that vector address but does not perform the save or the fetch.

The controller also handles two kinds of stall. A core that executes wait-for-interrupt is held until any of its interrupts is pending. A core that executes sync is held until every core has reached the barrier. The barrier then releases all waiting cores together and re-arms straight away. Each core also has a constant index output for the core-id query.

Top module: `mc_irq_barrier`

## Requirements
- R1: After reset every enable bit and pending latch is clear, so `take_irq`, `stall` and `sync_done` are all zero.
- R2: A hardware interrupt that arrives while its core is disabled is latched. `take_irq[i]` rises in the cycle after an enable request, as soon as both the enable bit and a pending bit are set.
- R3: A take lasts exactly one cycle. It clears that core's enable bit and both of its pending bits, and it takes priority over an enable request in the same cycle.
- R4: A hardware and a software interrupt that are pending together give a single take. After that take, no further take follows until something new arrives.
- R5: `swi_req[i]` sets the software pending bit of core i, and that bit is taken in the same way as the hardware one.
- R6: `ipi_req[s]` sets the hardware pending bit of the core whose index is `ipi_target[32*s+:32]`. A target index of `NC` or above has no effect on any core.
- R7: `di_req[i]` clears the enable bit and leaves pending bits unchanged. When `ei_req[i]` and `di_req[i]` arrive together, the disable wins.
- R8: `wfi_req[i]` sets `stall[i]` from the next cycle until the cycle after a pending bit of core i is seen. A wake while the core is disabled gives no take.
- R9: When core i is in a wait-for-interrupt stall with its enable bit set, `take_irq[i]` rises in the cycle the interrupt is latched, and `stall[i]` falls one cycle later.
- R10: `sync_req[i]` holds `stall[i]` high until every core has arrived. `sync_done` is high in the cycle the last core arrives, all barrier stalls drop on the next cycle, and the barrier accepts a new round at once. A core arriving in the completing cycle is never stalled.
- R11: `vec_addr[32*i+:32]` equals `VEC_BASE + i` (1000 + i by default), and `core_id[CIDW*i+:CIDW]` equals i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | NC | Hardware interrupt line per core |
| swi_req | input | NC | Software interrupt request per core |
| ei_req | input | NC | Enable-interrupt request per core |
| di_req | input | NC | Disable-interrupt request per core |
| ipi_req | input | NC | Inter-core interrupt send strobe per source core |
| ipi_target | input | NC*DW | Target core index per source core |
| wfi_req | input | NC | Wait-for-interrupt request per core |
| sync_req | input | NC | Barrier arrival per core |
| take_irq | output | NC | Take strobe: save PC to r31, jump through the vector |
| vec_addr | output | NC*DW | Vector word address per core |
| core_id | output | NC*CIDW | Constant core index per core |
| stall | output | NC | Hold the core (wait-for-interrupt or barrier) |
| sync_done | output | 1 | Barrier completes this cycle |

## Verification
The take path is driven by a table of enable, disable, hardware and software patterns spread across different cores. This separates latching from taking, take-over-enable priority from enable-over-disable priority, and one take from two when both sources are pending together. Inter-core sends are tried with an in-range target and with targets just past and far past the last core, which separates routing from dropping. Wait-for-interrupt is tried on a disabled core and on an enabled core to separate a plain wake from a wake with a take. The barrier is tried with staggered arrivals, with a second round straight after the first, and with all cores arriving in one cycle.

// File: rtl/mc_irq_barrier.sv
module mc_irq_barrier #(
  parameter int NC       = 4,
  parameter int DW       = 32,
  parameter int VEC_BASE = 1000,
  localparam int CIDW    = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NC-1:0]      hw_irq,
  input  logic [NC-1:0]      swi_req,
  input  logic [NC-1:0]      ei_req,
  input  logic [NC-1:0]      di_req,
  input  logic [NC-1:0]      ipi_req,
  input  logic [NC*DW-1:0]   ipi_target,
  input  logic [NC-1:0]      wfi_req,
  input  logic [NC-1:0]      sync_req,
  output logic [NC-1:0]      take_irq,
  output logic [NC*DW-1:0]   vec_addr,
  output logic [NC*CIDW-1:0] core_id,
  output logic [NC-1:0]      stall,
  output logic               sync_done
);

  logic [NC-1:0] en, pend_hw, pend_sw, wfi_st, arrived, ipi_hit, any_pend;

  always_comb begin
    ipi_hit = '0;
    for (int s = 0; s < NC; s++)
      if (ipi_req[s] && (ipi_target[s*DW +: DW] < DW'(NC)))
        ipi_hit[ipi_target[s*DW +: CIDW]] = 1'b1;
  end

  assign any_pend  = pend_hw | pend_sw;
  assign take_irq  = en & any_pend;
  assign sync_done = &(arrived | sync_req);
  assign stall     = wfi_st | arrived;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= '0;
      pend_hw <= '0;
      pend_sw <= '0;
      wfi_st  <= '0;
      arrived <= '0;
    end else begin
      en      <= (en | ei_req) & ~di_req & ~take_irq;
      pend_hw <= (pend_hw & ~take_irq) | hw_irq | ipi_hit;
      pend_sw <= (pend_sw & ~take_irq) | swi_req;
      wfi_st  <= (wfi_st | wfi_req) & ~any_pend;
      arrived <= sync_done ? '0 : (arrived | sync_req);
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_core
    assign vec_addr[i*DW +: DW]     = DW'(VEC_BASE + i);
    assign core_id[i*CIDW +: CIDW]  = CIDW'(i);
  end

endmodule

module mc_irq_barrier_chk #(
  parameter int NC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NC-1:0] take_irq,
  input logic [NC-1:0] hw_irq,
  input logic [NC-1:0] swi_req,
  input logic [NC-1:0] ipi_req,
  input logic [NC-1:0] ipi_hit,
  input logic [NC-1:0] pend_hw,
  input logic [NC-1:0] pend_sw,
  input logic [NC-1:0] wfi_st,
  input logic [NC-1:0] arrived,
  input logic          sync_done
);

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq != '0 |=> (take_irq & $past(take_irq)) == '0); // R3

  AST_TAKE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq != '0 |=> ((pend_hw | pend_sw) & $past(take_irq) & ~$past(hw_irq | swi_req | ipi_hit)) == '0); // R4

  AST_NO_SEND_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_req == '0 |-> ipi_hit == '0); // R6

  AST_WAKE_DROPS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wfi_st & (pend_hw | pend_sw)) != '0 |=> (wfi_st & $past(wfi_st & (pend_hw | pend_sw))) == '0); // R8

  AST_BARRIER_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |=> arrived == '0); // R10

endmodule

bind mc_irq_barrier mc_irq_barrier_chk #(.NC(NC)) chk_i (
  .clk(clk), .rst_n(rst_n), .take_irq(take_irq), .hw_irq(hw_irq),
  .swi_req(swi_req), .ipi_req(ipi_req), .ipi_hit(ipi_hit),
  .pend_hw(pend_hw), .pend_sw(pend_sw), .wfi_st(wfi_st),
  .arrived(arrived), .sync_done(sync_done)
);

// File: tb/mc_irq_barrier_tb_top.sv
`timescale 1ns/1ps
module mc_irq_barrier_tb_top;
  localparam int NC = 4;
  localparam int DW = 32;
  localparam int CIDW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] hw_irq = '0, swi_req = '0, ei_req = '0, di_req = '0;
  logic [NC-1:0] ipi_req = '0, wfi_req = '0, sync_req = '0;
  logic [NC*DW-1:0] ipi_target = '0;
  logic [NC-1:0] take_irq, stall;
  logic [NC*DW-1:0] vec_addr;
  logic [NC*CIDW-1:0] core_id;
  logic sync_done;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  mc_irq_barrier #(.NC(NC), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .swi_req(swi_req),
    .ei_req(ei_req), .di_req(di_req), .ipi_req(ipi_req), .ipi_target(ipi_target),
    .wfi_req(wfi_req), .sync_req(sync_req), .take_irq(take_irq),
    .vec_addr(vec_addr), .core_id(core_id), .stall(stall), .sync_done(sync_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    hw_irq = '0; swi_req = '0; ei_req = '0; di_req = '0;
    ipi_req = '0; wfi_req = '0; sync_req = '0;
  endtask

  // {hw, sw, ei, di, expected take after the edge}
  localparam logic [19:0] TBL [17] = '{
    {4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R2 latch while disabled
    {4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0001}, // R2 take after enable
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R3 one-cycle take
    {4'b0000, 4'b0010, 4'b0010, 4'b0000, 4'b0010}, // R5 software source
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R5
    {4'b0100, 4'b0100, 4'b0000, 4'b0000, 4'b0000}, // R4 both pending
    {4'b0000, 4'b0000, 4'b0100, 4'b0000, 4'b0100}, // R4 single take
    {4'b0000, 4'b0000, 4'b0100, 4'b0000, 4'b0000}, // R3 take beats enable, R4 no second
    {4'b0000, 4'b0000, 4'b1000, 4'b1000, 4'b0000}, // R7 disable wins
    {4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R7
    {4'b0000, 4'b0000, 4'b1000, 4'b0000, 4'b1000}, // R2
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R3
    {4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0000}, // R2 enable, nothing pending
    {4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0000}, // R7 disable
    {4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000}, // R7 latched only
    {4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0001}, // R7 pending kept
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000}  // R3
  };

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    check("R1 take in reset", 32'(take_irq), 32'h0);
    rst_n = 1'b1;
    step();
    check("R1 take", 32'(take_irq), 32'h0);
    check("R1 stall", 32'(stall), 32'h0);
    check("R1 sync_done", 32'(sync_done), 32'h0);

    for (int k = 0; k < 17; k++) begin
      {hw_irq, swi_req, ei_req, di_req} = TBL[k][19:4];
      step();
      check($sformatf("R%0d table row %0d", (k < 3) ? 2 : (k < 5 ? 5 : (k < 8 ? 4 : 7)), k),
            32'(take_irq), 32'(TBL[k][3:0]));
    end
    idle();

    // R6 routing
    ei_req = 4'b0100; step(); idle();
    ipi_req = 4'b0001; ipi_target[0 +: DW] = 32'd2; step(); idle();
    check("R6 routed to core 2", 32'(take_irq), 32'h4);
    step();
    // R6 out of range
    ei_req = 4'b1111; step(); idle();
    ipi_req = 4'b1010; ipi_target[1*DW +: DW] = 32'd4; ipi_target[3*DW +: DW] = 32'hFFFF_FFFF;
    step(); idle();
    check("R6 out-of-range ignored", 32'(take_irq), 32'h0);
    step();
    check("R6 still ignored", 32'(take_irq), 32'h0);
    di_req = 4'b1111; step(); idle();

    // R8 wfi on disabled core 1
    wfi_req = 4'b0010; step(); idle();
    check("R8 stall set", 32'(stall), 32'h2);
    step();
    check("R8 stall held", 32'(stall), 32'h2);
    hw_irq = 4'b0010; step(); idle();
    check("R8 stall at latch", 32'(stall), 32'h2);
    step();
    check("R8 woken", 32'(stall), 32'h0);
    check("R8 no take while disabled", 32'(take_irq), 32'h0);
    ei_req = 4'b0010; step(); idle(); step();

    // R9 wfi on enabled core 3
    ei_req = 4'b1000; step(); idle();
    wfi_req = 4'b1000; step(); idle();
    check("R9 stall set", 32'(stall), 32'h8);
    swi_req = 4'b1000; step(); idle();
    check("R9 take on latch", 32'(take_irq), 32'h8);
    check("R9 still stalled", 32'(stall), 32'h8);
    step();
    check("R9 stall released", 32'(stall), 32'h0);

    // R10 barrier
    sync_req = 4'b0001; #1;
    check("R10 not done", 32'(sync_done), 32'h0);
    step(); idle();
    check("R10 core 0 held", 32'(stall), 32'h1);
    sync_req = 4'b0100; step(); idle();
    check("R10 two held", 32'(stall), 32'h5);
    sync_req = 4'b1010; #1;
    check("R10 done on last", 32'(sync_done), 32'h1);
    step(); idle();
    check("R10 all released", 32'(stall), 32'h0);
    sync_req = 4'b0011; step(); idle();
    check("R10 re-armed", 32'(stall), 32'h3);
    sync_req = 4'b1100; #1;
    check("R10 second round done", 32'(sync_done), 32'h1);
    step(); idle();
    check("R10 second release", 32'(stall), 32'h0);
    sync_req = 4'b1111; #1;
    check("R10 all at once", 32'(sync_done), 32'h1);
    step(); idle();
    check("R10 no stall", 32'(stall), 32'h0);

    // R11 vector and id
    for (int i = 0; i < NC; i++) begin
      check("R11 vector", vec_addr[i*DW +: DW], 32'(1000 + i));
      check("R11 core id", 32'(core_id[i*CIDW +: CIDW]), 32'(i));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule